// File: doc/BRIEF.md
# Automatic Fuse Word Read Engine

This block reads one 32-bit word out of a small fuse array on a single software command. Software writes the auto-control register with the word address and with both the enable and the read bits set. A hardware sequencer then holds the array access for a fixed number of clock cycles. At the end it captures the word into a read-only data register and raises a sticky finish flag. Software polls the flag, reads the data, and clears the flag by writing a one to it.

The array is modelled as a preloaded memory of `NWORDS` 32-bit words, 32 by default (128 bytes). Words 0 to 23 form the secure part and words 24 to 31 the open part. Access policy for the secure part is not handled here. The register interface is a simple single-cycle request port with byte offsets. Read data is registered: it appears the cycle after the request and holds until the next read.

Top module: `fuse_auto_reader`

## Requirements
- R1: After reset, reads of the control (0x24), status (0x18) and data (0x20) registers all return zero.
- R2: The control register keeps enable in bit 0, read-request in bit 1 and the 10-bit word address in bits 25:16. All other bits read as zero. Any register read returns its value on `bus_rdata` one clock after the request, and that value holds until the next read.
- R3: A control write that sets both bit 0 and bit 1 while the engine is idle starts a read. The finish flag (status bit 0) becomes set exactly `ACC_CYCLES` clock edges after the edge that accepted the write.
- R4: The data register returns word `i = address mod NWORDS`, whose content is `(i+1) * 0x9E3779B1` modulo 2^32. It changes only on the edge that completes an access.
- R5: On completion the read-request bit clears by itself. The enable bit and the address stay as written.
- R6: A write to the control register while an access is in progress is ignored completely: no new read starts and the register keeps its contents.
- R7: Writing status bit 0 as one clears the finish flag. Writing it as zero leaves it unchanged. Once set, the flag stays set until such a clear.
- R8: A control write with only one of bits 0 and 1 set stores the value but starts no read. The flag and the data register stay unchanged.
- R9: Reads of unmapped offsets return zero. Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Take the edge that accepts the start write as E0. A status read issued on edge E0+k returns the flag as it stood before that edge. So the bench polls every cycle after the start and expects zero up to k = `ACC_CYCLES` and one from k = `ACC_CYCLES`+1. Data and control values are checked by reads issued after the flag has been observed set, because by then the capture edge has passed. A data read issued during the access window is expected to return the previous word. Every read result is sampled on the falling edge after its request edge.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int REG_AW   = 8;
    localparam int WORD_W   = 32;
    localparam int FADDR_W  = 10;
    localparam int FADDR_LSB = 16;

    localparam logic [REG_AW-1:0] OFF_STAT = 8'h18;
    localparam logic [REG_AW-1:0] OFF_DATA = 8'h20;
    localparam logic [REG_AW-1:0] OFF_CTRL = 8'h24;

    localparam logic [WORD_W-1:0] FILL_MULT = 32'h9E37_79B1;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_DONE   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [FADDR_W-1:0] waddr;
        logic               rd;
        logic               en;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] v;
        v = '0;
        v[0] = c.en;
        v[1] = c.rd;
        v[FADDR_LSB +: FADDR_W] = c.waddr;
        return v;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] v);
        ctrl_t c;
        c.en    = v[0];
        c.rd    = v[1];
        c.waddr = v[FADDR_LSB +: FADDR_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] fuse_fill(input int unsigned idx);
        logic [WORD_W-1:0] n;
        n = WORD_W'(idx + 1);
        return n * FILL_MULT;
    endfunction

endpackage

// File: rtl/fuse_array.sv
module fuse_array
    import fuse_pkg::*;
#(
    parameter int NWORDS = 32,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] cells [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_cell
        assign cells[g] = fuse_fill(g);
    end

    assign word = cells[idx];

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int ACC_CYCLES = 8,
    localparam int CNT_W = $clog2(ACC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done_evt
);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy     = (state_q != SEQ_IDLE);
    assign done_evt = (state_q == SEQ_ACCESS) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_ACCESS;
                        cnt_q   <= CNT_W'(ACC_CYCLES - 1);
                    end
                end
                SEQ_ACCESS: begin
                    if (cnt_q == '0) state_q <= SEQ_DONE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                SEQ_DONE:   state_q <= SEQ_IDLE;
                default:    state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R3: an accepted start always enters the access phase
    a_r3_start_enters: assert property (@(posedge clk) disable iff (rst)
        start |=> (state_q == SEQ_ACCESS));

    // R3: completion phase lasts one cycle
    a_r3_done_returns: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_DONE) |=> (state_q == SEQ_IDLE));

    // R6: register block never issues a start while busy
    a_r6_no_start_busy: assert property (@(posedge clk) disable iff (rst)
        !(start && busy));

    // R3: counter stays inside its window
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ACC_CYCLES - 1));

endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
    import fuse_pkg::*;
#(
    parameter int NWORDS = 32,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               busy,
    input  logic               done_evt,
    input  logic [WORD_W-1:0]  fuse_word,
    output logic               start,
    output logic [IDX_W-1:0]   word_idx
);

    ctrl_t             ctrl_q, ctrl_d;
    logic              finish_q;
    logic [WORD_W-1:0] dout_q;
    logic [WORD_W-1:0] rdata_q;
    logic              wr_ctrl, wr_stat, rd_req;
    ctrl_t             wr_val;

    assign wr_ctrl = bus_valid && bus_write && (bus_addr == OFF_CTRL);
    assign wr_stat = bus_valid && bus_write && (bus_addr == OFF_STAT);
    assign rd_req  = bus_valid && !bus_write;
    assign wr_val  = unpack_ctrl(bus_wdata);

    assign start    = wr_ctrl && !busy && wr_val.en && wr_val.rd;
    assign word_idx = ctrl_q.waddr[IDX_W-1:0];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl && !busy) ctrl_d = wr_val;
        else if (done_evt)    ctrl_d.rd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            finish_q <= 1'b0;
            dout_q   <= '0;
            rdata_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (done_evt)                     finish_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) finish_q <= 1'b0;
            if (done_evt) dout_q <= fuse_word;
            if (rd_req) begin
                unique case (bus_addr)
                    OFF_CTRL: rdata_q <= pack_ctrl(ctrl_q);
                    OFF_STAT: rdata_q <= {{(WORD_W-1){1'b0}}, finish_q};
                    OFF_DATA: rdata_q <= dout_q;
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    assign bus_rdata = rdata_q;

    // R4: data register moves only on completion
    a_r4_dout_hold: assert property (@(posedge clk) disable iff (rst)
        !done_evt |=> $stable(dout_q));

    // R7: finish is sticky unless a one is written to it
    a_r7_finish_sticky: assert property (@(posedge clk) disable iff (rst)
        (finish_q && !(wr_stat && bus_wdata[0])) |=> finish_q);

    // R5: read request drops after completion
    a_r5_rd_selfclear: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> !ctrl_q.rd);

    // R6: control writes during an access leave the register alone
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !done_evt && wr_ctrl) |=> $stable(ctrl_q));

endmodule

// File: rtl/fuse_auto_reader.sv
module fuse_auto_reader
    import fuse_pkg::*;
#(
    parameter int NWORDS     = 32,
    parameter int ACC_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int IDX_W = $clog2(NWORDS);

    logic              start, busy, done_evt;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] fuse_word;

    fuse_regs #(.NWORDS(NWORDS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done_evt  (done_evt),
        .fuse_word (fuse_word),
        .start     (start),
        .word_idx  (word_idx)
    );

    fuse_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .busy     (busy),
        .done_evt (done_evt)
    );

    fuse_array #(.NWORDS(NWORDS)) u_array (
        .idx  (word_idx),
        .word (fuse_word)
    );

endmodule

// File: tb/fuse_auto_reader_tb.sv
module fuse_auto_reader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NW  = 32;
    localparam int ACC = 8;
    localparam logic [7:0] A_STAT = 8'h18;
    localparam logic [7:0] A_DATA = 8'h20;
    localparam logic [7:0] A_CTRL = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] exp_dout = '0;
    logic [31:0] rv;

    fuse_auto_reader #(.NWORDS(NW), .ACC_CYCLES(ACC)) dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_word(input logic [9:0] a);
        logic [31:0] i;
        i = 32'(a % NW) + 32'd1;
        return i * 32'h9E37_79B1;
    endfunction

    function automatic logic [31:0] ctrl_val(input logic [9:0] a, input logic rd, input logic en);
        return {6'b0, a, 14'b0, rd, en};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_finish(input string req);
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 4 * ACC && s[0] !== 1'b1; i++) rd(A_STAT, s);
        check(req, s, 32'd1);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                summary();
            end
        end
    end

    initial begin
        logic [9:0] a, b;
        void'($urandom(32'd2024));
        idle(3);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
        rd(A_STAT, rv); check("R1 stat", rv, 0);
        rd(A_DATA, rv); check("R1 data", rv, 0);

        // R9 unmapped read, data write ignored
        rd(8'h04, rv); check("R9 unmapped", rv, 0);
        wr(A_DATA, 32'hDEAD_BEEF);
        rd(A_DATA, rv); check("R9 data ro", rv, 0);

        // R2 layout: address with enable only, no start (R8)
        wr(A_CTRL, 32'hFFFF_FFFD);
        rd(A_CTRL, rv); check("R2 ctrl mask", rv, ctrl_val(10'h3FF, 1'b0, 1'b1));
        idle(ACC + 3);
        rd(A_STAT, rv); check("R8 no start en-only", rv, 0);
        wr(A_CTRL, ctrl_val(10'd5, 1'b1, 1'b0));
        idle(ACC + 3);
        rd(A_STAT, rv); check("R8 no start rd-only", rv, 0);
        rd(A_DATA, rv); check("R8 data kept", rv, 0);
        rd(A_CTRL, rv); check("R2 ctrl rd-only stored", rv, ctrl_val(10'd5, 1'b1, 1'b0));

        // R3 exact timing, R4 data hold during access
        a = 10'd25;
        wr(A_CTRL, ctrl_val(a, 1'b1, 1'b1));
        for (int j = 1; j <= ACC + 1; j++) begin
            if (j == 2) begin
                rd(A_DATA, rv); check("R4 data held in access", rv, exp_dout);
            end else begin
                rd(A_STAT, rv);
                check($sformatf("R3 finish at +%0d", j), rv, (j >= ACC + 1) ? 32'd1 : 32'd0);
            end
        end
        exp_dout = exp_word(a);
        rd(A_DATA, rv); check("R4 word 25", rv, exp_dout);
        rd(A_CTRL, rv); check("R5 rd cleared", rv, ctrl_val(a, 1'b0, 1'b1));
        rd(A_DATA, rv); check("R2 read repeat", rv, exp_dout);

        // R7 write zero keeps, write one clears
        wr(A_STAT, 32'hFFFF_FFFE);
        idle(2);
        rd(A_STAT, rv); check("R7 zero write keeps", rv, 1);
        wr(A_STAT, 32'h1);
        rd(A_STAT, rv); check("R7 one write clears", rv, 0);
        idle(ACC);
        rd(A_STAT, rv); check("R7 stays clear", rv, 0);

        // R4 boundary: address wraps modulo array size; top words
        a = 10'h3FF;
        wr(A_CTRL, ctrl_val(a, 1'b1, 1'b1));
        wait_finish("R3 wrap finish");
        exp_dout = exp_word(a);
        rd(A_DATA, rv); check("R4 wrap word", rv, exp_dout);
        wr(A_STAT, 32'h1);

        // random with busy rewrites
        for (int it = 0; it < 40; it++) begin
            a = 10'($urandom);
            b = 10'($urandom);
            wr(A_CTRL, ctrl_val(a, 1'b1, 1'b1));
            if (it % 2 == 0) begin
                wr(A_CTRL, ctrl_val(b, 1'b1, 1'b1));
                rd(A_CTRL, rv); check("R6 busy write ignored", rv, ctrl_val(a, 1'b1, 1'b1));
            end
            wait_finish("R3 random finish");
            exp_dout = exp_word(a);
            rd(A_DATA, rv); check("R4 random word", rv, exp_dout);
            rd(A_CTRL, rv); check("R5 random ctrl", rv, ctrl_val(a, 1'b0, 1'b1));
            if (it % 3 == 0) begin
                wr(A_STAT, 32'h0);
                rd(A_STAT, rv); check("R7 random sticky", rv, 1);
            end
            wr(A_STAT, 32'h1);
            rd(A_STAT, rv); check("R7 random clear", rv, 0);
            idle(ACC + 2);
            rd(A_STAT, rv); check("R6 no second read", rv, 0);
        end

        summary();
    end

endmodule